// File: doc/BRIEF.md
# Protocol Discovery Responder

This block is the built-in responder that sits behind a data-object mailbox. A register block collects a request object into a write buffer. It then pulses `start_i` together with the number of dwords that were written. The responder reads the first three dwords of the buffer through a read port with one cycle of latency. It decodes the first header dword and checks that the dword count agrees with the length field in the second header dword.

A discovery request is answered by writing a three-dword response into the read buffer, and then a one-cycle `done_o` pulse with `ok_o` high. The register block uses that pulse to raise its ready flag. A request that is malformed, short or unknown ends in `done_o` with `ok_o` low, and the register block then clears its mailboxes.

A request whose header matches one entry of the parameter table of supported protocols is handed on. The block pulses `disp_valid_o` with the table position on `disp_idx_o`, and an external handler takes over. The discovery reply walks the supported protocols by index: index 0 is discovery itself, later indices map onto table entries, and a next-index field closes the chain with 0.

Top module: `doe_disc_responder`

## Requirements
- R1: Header dword 0 holds the vendor ID in bits 15:0 and the object type in bits 23:16. Bits 31:24 must be zero for any header to match. Header dword 1 holds the length in dwords in bits LEN_W-1:0, and a length field of 0 stands for 2^LEN_W dwords.
- R2: `start_i` is acted on only while the block is idle. A start pulse that arrives while a request is in progress has no effect: it causes no second fetch, no second done and no extra write.
- R3: The discovery identifier (vendor 0x0001, type 0x00) is compared first. The table is then searched from entry 0 upward, and the first match wins. A table match pulses `disp_valid_o` for one cycle with the 0-based entry position, and `done_o` is not raised.
- R4: A request is discarded with `done_o` high and `ok_o` low in any of these cases: fewer than 2 dwords were written, the dword count differs from the decoded length, or the header matches nothing. A discarded request writes nothing to the read buffer.
- R5: A discovery request whose length is under 3 dwords fails and writes nothing.
- R6: A successful discovery writes read-buffer addresses 0, 1 and 2 on three consecutive cycles. The three dwords are the discovery header, then the length dword 3, then an entry dword holding next index[31:24], object type[23:16] and vendor ID[15:0].
- R7: The requested index is the low byte of request dword 2. Index 0 reports the discovery protocol. Index k, for 1 ≤ k < PROT_NUM+1, reports table entry k-1.
- R8: An index at or above the protocol count PROT_NUM+1 reports vendor 0xFFFF and type 0xFF.
- R9: The next index is 0 when index+1 equals the protocol count. Otherwise it is index+1, taken modulo 256.
- R10: `done_o` is a one-cycle pulse, with `ok_o` valid only during it. If start is sampled at edge n, success shows after edge n+7, and failure or dispatch after edge n+4.
- R11: The write buffer is read at addresses 0, 1 and 2 on the three cycles right after the start edge, and data returns one cycle after its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request-complete strobe |
| req_cnt_i | input | LEN_W+1 | Dwords written into the write buffer |
| wbuf_rd_o | output | 1 | Write-buffer read enable |
| wbuf_addr_o | output | ADDR_W | Write-buffer read address |
| wbuf_data_i | input | 32 | Write-buffer read data, one cycle after address |
| rbuf_we_o | output | 1 | Read-buffer write enable |
| rbuf_addr_o | output | ADDR_W | Read-buffer write address |
| rbuf_data_o | output | 32 | Read-buffer write data |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Success flag during done |
| disp_valid_o | output | 1 | One-cycle dispatch pulse for a table protocol |
| disp_idx_o | output | IDW | Matching table entry position |

## Verification
Fetch reads are due on the first, second and third cycles after the edge that samples start. A fail or dispatch outcome is due four edges after that edge, response writes come on edges five to seven, and success done comes on edge eight. Each scenario task drives start at a falling edge and then samples every output at each following falling edge. It records the exact edge number on which each event first appears and compares that number with these constants. Writes and done pulses are counted over a fixed window, so a late, early or duplicated event is reported.

// File: rtl/doe_disc_pkg.sv
package doe_disc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH0, ST_FETCH1, ST_FETCH2, ST_DECIDE,
    ST_RSP0, ST_RSP1, ST_RSP2, ST_FIN, ST_DISP
  } rsp_state_e;

  typedef struct packed {
    logic [7:0]  nxt;
    logic [7:0]  otype;
    logic [15:0] vid;
  } disc_entry_t;

  // header dword 0 built from an identifier pair, top byte zero
  function automatic logic [31:0] id_word(input logic [15:0] vid, input logic [7:0] otype);
    return {8'h00, otype, vid};
  endfunction

  // successor index in the discovery chain, 0 closes it
  function automatic logic [7:0] next_index(input logic [7:0] idx, input logic [8:0] count);
    logic [8:0] succ;
    succ = {1'b0, idx} + 9'd1;
    return (succ == count) ? 8'h00 : succ[7:0];
  endfunction

endpackage

// File: rtl/doe_hdr_match.sv
module doe_hdr_match
  import doe_disc_pkg::*;
#(
  parameter int unsigned PROT_NUM = 2,
  parameter logic [PROT_NUM*24-1:0] PROT_TABLE = '0,
  parameter logic [15:0] DISC_VID = 16'h0001,
  parameter logic [7:0]  DISC_TYPE = 8'h00,
  localparam int unsigned IDW = (PROT_NUM > 1) ? $clog2(PROT_NUM) : 1
) (
  input  logic [31:0]    hdr0_i,
  output logic           disc_hit_o,
  output logic           tab_hit_o,
  output logic [IDW-1:0] tab_idx_o
);

  logic [PROT_NUM-1:0] entry_match;

  for (genvar g = 0; g < PROT_NUM; g++) begin : g_cmp
    assign entry_match[g] = (hdr0_i == {8'h00, PROT_TABLE[g*24 +: 24]});
  end

  assign disc_hit_o = (hdr0_i == id_word(DISC_VID, DISC_TYPE));
  assign tab_hit_o  = !disc_hit_o && (|entry_match);

  // lowest position wins: scan downward so the last write is the smallest
  always_comb begin
    tab_idx_o = '0;
    for (int k = PROT_NUM - 1; k >= 0; k--) begin
      if (entry_match[k]) tab_idx_o = IDW'(k);
    end
  end

endmodule

// File: rtl/doe_entry_gen.sv
module doe_entry_gen
  import doe_disc_pkg::*;
#(
  parameter int unsigned PROT_NUM = 2,
  parameter logic [PROT_NUM*24-1:0] PROT_TABLE = '0,
  parameter logic [15:0] DISC_VID = 16'h0001,
  parameter logic [7:0]  DISC_TYPE = 8'h00
) (
  input  logic [7:0]  index_i,
  output logic [31:0] entry_o
);

  localparam logic [8:0] PCOUNT = 9'(PROT_NUM + 1);

  disc_entry_t ent;

  always_comb begin
    ent.nxt   = next_index(index_i, PCOUNT);
    ent.vid   = 16'hFFFF;
    ent.otype = 8'hFF;
    if (index_i == 8'd0) begin
      ent.vid   = DISC_VID;
      ent.otype = DISC_TYPE;
    end else begin
      for (int k = 0; k < PROT_NUM; k++) begin
        if ({1'b0, index_i} == 9'(k + 1)) begin
          ent.vid   = PROT_TABLE[k*24 +: 16];
          ent.otype = PROT_TABLE[k*24 + 16 +: 8];
        end
      end
    end
  end

  assign entry_o = ent;

endmodule

// File: rtl/doe_disc_responder.sv
module doe_disc_responder
  import doe_disc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LEN_W = 18,
  parameter int unsigned PROT_NUM = 2,
  parameter logic [PROT_NUM*24-1:0] PROT_TABLE = {24'h07_1234, 24'h05_ABCD},
  parameter logic [15:0] DISC_VID = 16'h0001,
  parameter logic [7:0]  DISC_TYPE = 8'h00,
  localparam int unsigned IDW = (PROT_NUM > 1) ? $clog2(PROT_NUM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W:0]    req_cnt_i,
  output logic              wbuf_rd_o,
  output logic [ADDR_W-1:0] wbuf_addr_o,
  input  logic [31:0]       wbuf_data_i,
  output logic              rbuf_we_o,
  output logic [ADDR_W-1:0] rbuf_addr_o,
  output logic [31:0]       rbuf_data_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              disp_valid_o,
  output logic [IDW-1:0]    disp_idx_o
);

  localparam logic [LEN_W:0] MIN_HDR  = (LEN_W+1)'(2);
  localparam logic [LEN_W:0] DISC_LEN = (LEN_W+1)'(3);

  // decoded object length; field value 0 means the largest object
  function automatic logic [LEN_W:0] obj_len(input logic [LEN_W-1:0] fld);
    return (fld == '0) ? ((LEN_W+1)'(1) << LEN_W) : {1'b0, fld};
  endfunction

  rsp_state_e       state_q, state_d;
  logic [31:0]      hdr0_q;
  logic [LEN_W-1:0] lenf_q;
  logic [LEN_W:0]   cnt_q;
  logic [7:0]       idx_q;
  logic             ok_q;
  logic [IDW-1:0]   disp_q;

  // named internal events
  logic           idle_w, req_taken_w, cnt_ok_w, disc_long_w;
  logic           disc_hit_w, tab_hit_w, go_rsp_w, go_disp_w;
  logic [IDW-1:0] tab_idx_w;
  logic [31:0]    entry_w;
  logic [LEN_W:0] dec_len_w;

  doe_hdr_match #(
    .PROT_NUM(PROT_NUM), .PROT_TABLE(PROT_TABLE),
    .DISC_VID(DISC_VID), .DISC_TYPE(DISC_TYPE)
  ) u_match (
    .hdr0_i(hdr0_q), .disc_hit_o(disc_hit_w),
    .tab_hit_o(tab_hit_w), .tab_idx_o(tab_idx_w)
  );

  doe_entry_gen #(
    .PROT_NUM(PROT_NUM), .PROT_TABLE(PROT_TABLE),
    .DISC_VID(DISC_VID), .DISC_TYPE(DISC_TYPE)
  ) u_entry (
    .index_i(idx_q), .entry_o(entry_w)
  );

  assign idle_w      = (state_q == ST_IDLE);
  assign req_taken_w = idle_w && start_i;
  assign dec_len_w   = obj_len(lenf_q);
  assign cnt_ok_w    = (cnt_q >= MIN_HDR) && (cnt_q == dec_len_w);
  assign disc_long_w = (dec_len_w >= DISC_LEN);
  assign go_rsp_w    = disc_hit_w && cnt_ok_w && disc_long_w;
  assign go_disp_w   = tab_hit_w && cnt_ok_w;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_FETCH0;
      ST_FETCH0: state_d = ST_FETCH1;
      ST_FETCH1: state_d = ST_FETCH2;
      ST_FETCH2: state_d = ST_DECIDE;
      ST_DECIDE: state_d = go_rsp_w ? ST_RSP0 : (go_disp_w ? ST_DISP : ST_FIN);
      ST_RSP0:   state_d = ST_RSP1;
      ST_RSP1:   state_d = ST_RSP2;
      ST_RSP2:   state_d = ST_FIN;
      ST_FIN:    state_d = ST_IDLE;
      ST_DISP:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr0_q  <= '0;
      lenf_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      ok_q    <= 1'b0;
      disp_q  <= '0;
    end else begin
      state_q <= state_d;
      if (req_taken_w)              cnt_q  <= req_cnt_i;
      if (state_q == ST_FETCH1)     hdr0_q <= wbuf_data_i;
      if (state_q == ST_FETCH2)     lenf_q <= wbuf_data_i[LEN_W-1:0];
      if (state_q == ST_DECIDE) begin
        idx_q  <= wbuf_data_i[7:0];
        ok_q   <= go_rsp_w;
        disp_q <= tab_idx_w;
      end
    end
  end

  // write-buffer fetch port
  always_comb begin
    wbuf_rd_o   = 1'b1;
    wbuf_addr_o = '0;
    unique case (state_q)
      ST_FETCH0: wbuf_addr_o = ADDR_W'(0);
      ST_FETCH1: wbuf_addr_o = ADDR_W'(1);
      ST_FETCH2: wbuf_addr_o = ADDR_W'(2);
      default:   wbuf_rd_o   = 1'b0;
    endcase
  end

  // read-buffer response port
  always_comb begin
    rbuf_we_o   = 1'b1;
    rbuf_addr_o = '0;
    rbuf_data_o = '0;
    unique case (state_q)
      ST_RSP0: rbuf_data_o = id_word(DISC_VID, DISC_TYPE);
      ST_RSP1: begin
        rbuf_addr_o = ADDR_W'(1);
        rbuf_data_o = 32'(DISC_LEN);
      end
      ST_RSP2: begin
        rbuf_addr_o = ADDR_W'(2);
        rbuf_data_o = entry_w;
      end
      default: rbuf_we_o = 1'b0;
    endcase
  end

  assign done_o       = (state_q == ST_FIN);
  assign ok_o         = done_o && ok_q;
  assign disp_valid_o = (state_q == ST_DISP);
  assign disp_idx_o   = disp_valid_o ? disp_q : '0;

endmodule

// File: rtl/doe_disc_checker.sv
module doe_disc_checker #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              idle_w,
  input logic              wbuf_rd_o,
  input logic [ADDR_W-1:0] wbuf_addr_o,
  input logic              rbuf_we_o,
  input logic [ADDR_W-1:0] rbuf_addr_o,
  input logic [31:0]       rbuf_data_o,
  input logic              done_o,
  input logic              ok_o,
  input logic              disp_valid_o
);

  assert_fetch_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle_w) |=> (wbuf_rd_o && wbuf_addr_o == '0));

  assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !idle_w) |=> !(wbuf_rd_o && wbuf_addr_o == '0));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_disp_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && disp_valid_o));

  assert_len_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rbuf_we_o && rbuf_addr_o == ADDR_W'(1)) |-> (rbuf_data_o == 32'd3));

  assert_write_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rbuf_we_o && rbuf_addr_o == '0) |=> (rbuf_we_o && rbuf_addr_o == ADDR_W'(1)));

  assert_ok_after_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ok_o) |-> $past(rbuf_we_o && rbuf_addr_o == ADDR_W'(2)));

  assert_fail_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ok_o) |-> !$past(rbuf_we_o));

endmodule

bind doe_disc_responder doe_disc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .idle_w(idle_w),
  .wbuf_rd_o(wbuf_rd_o), .wbuf_addr_o(wbuf_addr_o),
  .rbuf_we_o(rbuf_we_o), .rbuf_addr_o(rbuf_addr_o), .rbuf_data_o(rbuf_data_o),
  .done_o(done_o), .ok_o(ok_o), .disp_valid_o(disp_valid_o)
);

// File: tb/doe_disc_responder_bench.sv
`timescale 1ns/1ps
module doe_disc_responder_bench;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned LEN_W = 18;
  localparam int unsigned PROT_NUM = 3;
  // entry 0: BEEF/11, entry 1: CAFE/22, entry 2: BEEF/11 again
  localparam logic [PROT_NUM*24-1:0] TABLE = {24'h11_BEEF, 24'h22_CAFE, 24'h11_BEEF};
  localparam int IDW = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LEN_W:0] req_cnt = '0;
  logic wbuf_rd, rbuf_we, done, ok, disp_valid;
  logic [ADDR_W-1:0] wbuf_addr, rbuf_addr;
  logic [31:0] wbuf_data = '0, rbuf_data;
  logic [IDW-1:0] disp_idx;

  logic [31:0] wmem [0:15];

  int n_tests = 0, n_fail = 0;
  int done_at, ok_seen, disp_at, didx, nwr, ndone, ndisp, rd0_at;
  logic [31:0] rb [0:3];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) if (wbuf_rd) wbuf_data <= wmem[wbuf_addr];

  doe_disc_responder #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PROT_NUM(PROT_NUM), .PROT_TABLE(TABLE),
    .DISC_VID(16'h0001), .DISC_TYPE(8'h00)
  ) u_doe_disc_responder (
    .clk(clk), .rst_n(rst_n), .start_i(start), .req_cnt_i(req_cnt),
    .wbuf_rd_o(wbuf_rd), .wbuf_addr_o(wbuf_addr), .wbuf_data_i(wbuf_data),
    .rbuf_we_o(rbuf_we), .rbuf_addr_o(rbuf_addr), .rbuf_data_o(rbuf_data),
    .done_o(done), .ok_o(ok), .disp_valid_o(disp_valid), .disp_idx_o(disp_idx)
  );

  task automatic chk(input bit good, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // expected entry dword, restated from R7/R8/R9
  function automatic logic [31:0] exp_entry(input int idx);
    int cnt = PROT_NUM + 1;
    logic [7:0] nx;
    logic [23:0] body;
    nx = (idx + 1 == cnt) ? 8'd0 : 8'((idx + 1) % 256);
    if (idx == 0) body = 24'h00_0001;
    else if (idx < cnt) body = TABLE[(idx-1)*24 +: 24];
    else body = 24'hFF_FFFF;
    return {nx, body};
  endfunction

  task automatic load(input logic [31:0] w0, input logic [31:0] w1,
                      input logic [31:0] w2, input int cnt);
    wmem[0] = w0; wmem[1] = w1; wmem[2] = w2;
    req_cnt = (LEN_W+1)'(cnt);
  endtask

  task automatic go(input bit restart);
    done_at = 0; ok_seen = 0; disp_at = 0; didx = 0; nwr = 0;
    ndone = 0; ndisp = 0; rd0_at = 0;
    for (int j = 0; j < 4; j++) rb[j] = 32'h0;
    @(negedge clk) start = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (i == 1) start = 1'b0;
      if (restart && i == 2) start = 1'b1;
      if (restart && i == 3) start = 1'b0;
      if (done) begin
        ndone++;
        if (done_at == 0) begin done_at = i; ok_seen = int'(ok); end
      end
      if (disp_valid) begin
        ndisp++;
        if (disp_at == 0) begin disp_at = i; didx = int'(disp_idx); end
      end
      if (rbuf_we) begin nwr++; rb[rbuf_addr[1:0]] = rbuf_data; end
      if (wbuf_rd && wbuf_addr == '0 && rd0_at == 0) rd0_at = i;
    end
  endtask

  task automatic t_reset;
    chk(!done && !disp_valid && !rbuf_we && !wbuf_rd, "R10", "idle outputs after reset",
        {28'h0, done, disp_valid, rbuf_we, wbuf_rd}, 32'h0);
  endtask

  task automatic t_disc(input int idx);
    load(32'h0000_0001, 32'd3, 32'(idx), 3);
    go(1'b0);
    chk(rd0_at == 1, "R11", "fetch of dword 0 edge", rd0_at, 1);
    chk(done_at == 8 && ok_seen == 1, "R10", "success done edge/ok", done_at, 8);
    chk(nwr == 3 && ndone == 1, "R6", "write count", nwr, 3);
    chk(rb[0] == 32'h0000_0001, "R6", "response header", rb[0], 32'h1);
    chk(rb[1] == 32'd3, "R6", "response length", rb[1], 3);
    chk(rb[2] == exp_entry(idx), (idx >= PROT_NUM + 1) ? "R8" : "R7",
        $sformatf("entry for index %0d (next per R9)", idx), rb[2], exp_entry(idx));
  endtask

  task automatic t_fail(input logic [31:0] w0, input logic [31:0] w1, input int cnt,
                        input string req, input string what);
    load(w0, w1, 32'h0, cnt);
    go(1'b0);
    chk(done_at == 5 && ok_seen == 0, req, {what, " fail done edge"}, done_at, 5);
    chk(nwr == 0 && ndisp == 0, req, {what, " no write/dispatch"}, nwr + ndisp, 0);
  endtask

  task automatic t_disp(input logic [31:0] w0, input int exp_idx);
    load(w0, 32'd2, 32'h0, 2);
    go(1'b0);
    chk(disp_at == 5 && ndisp == 1, "R3", "dispatch edge", disp_at, 5);
    chk(didx == exp_idx, "R3", "dispatch entry position", didx, exp_idx);
    chk(ndone == 0 && nwr == 0, "R3", "no done on dispatch", ndone + nwr, 0);
  endtask

  task automatic t_busy;
    load(32'h0000_0001, 32'd3, 32'd1, 3);
    go(1'b1);
    chk(ndone == 1 && done_at == 8, "R2", "single done despite busy start", ndone, 1);
    chk(nwr == 3, "R2", "no extra writes from busy start", nwr, 3);
    chk(rb[2] == exp_entry(1), "R2", "entry unchanged", rb[2], exp_entry(1));
  endtask

  initial begin
    for (int j = 0; j < 16; j++) wmem[j] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_disc(0);     // R7 discovery itself, R9 next 1
    t_disc(1);     // R7 entry 0
    t_disc(2);     // R7 entry 1
    t_disc(3);     // R9 last, next 0
    t_disc(4);     // R8 out of range
    t_disc(255);   // R8, R9 wrap
    t_fail(32'h0000_0001, 32'd2, 2, "R5", "two-dword discovery");
    t_fail(32'h0000_0001, 32'd3, 4, "R4", "count mismatch");
    t_fail(32'h0000_0001, 32'd0, 3, "R1", "zero length field");
    t_fail(32'h0100_0001, 32'd3, 3, "R1", "nonzero top byte");
    t_fail(32'h0033_0000, 32'd3, 3, "R4", "unknown header");
    t_fail(32'h0022_CAFE, 32'd2, 1, "R4", "single dword");
    t_disp(32'h0011_BEEF, 0);  // R3 first match of duplicates
    t_disp(32'h0022_CAFE, 1);
    t_busy();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule